// File: doc/BRIEF.md
# Bit-Clock Paced Serial Transmit Engine

This block sits on the host side of a link to an external line encoder. It sends a frame of bytes one bit at a time. The encoder sets the pace: once the engine raises its transmit-enable output, the encoder toggles a bit clock, and the engine places each new bit on its data output. The encoder latches that bit on the next falling edge of the bit clock. The engine does no framing checks and does no encoding of its own. Parity bits, when used, are already present in the stored words.

A frame is described by three values: a byte count, a parity flag, and a word store that the engine reads through a simple address/data port. A start pulse begins the frame. The engine fetches each 16-bit word and sends its low 8 bits, or its low 9 bits when parity is on. The lowest bit goes first. After the last bit, the engine keeps the link enabled for one more bit-clock cycle. It then drops the enable and waits one final cycle before it reports done. An interrupt or a timeout from the surrounding system ends the frame at once. In that case the engine flags the frame as aborted.

Top module: `bclk_tx_engine`

## Requirements
- R1: After reset, tx_en_o, tx_data_o, busy_o, done_o and aborted_o are all 0.
- R2: start_i is accepted only while busy_o is 0. A start pulse during a frame changes neither the bits sent nor the frame length.
- R3: tx_data_o is 0 in the cycle in which tx_en_o rises, and again once the frame has ended.
- R4: rd_addr_o carries the index of the byte word being fetched, counting from 0. rd_data_i is taken one cycle after the address is presented. tx_en_o rises only after the first word has been loaded.
- R5: While tx_en_o is high, tx_data_o changes only right after a rising edge of the synchronized bit clock. It then holds until the next rising edge, so it is stable at the falling edge where the encoder latches it.
- R6: Bits of each word are sent least significant bit first, and words are sent in increasing address order.
- R7: With parity_en_i = 1, each word sends bits 0 to 8, with bit 8 being the parity bit. With parity_en_i = 0, each word sends bits 0 to 7. Word bits above the sent width have no effect.
- R8: After the falling edge that latches the last bit, tx_en_o stays high until the next rising edge of the bit clock, then drops. done_o pulses for one cycle after one further full bit-clock cycle. Counted from the start of the frame, done therefore follows the (N+1)-th falling edge, where N is the number of bits.
- R9: A byte count of 0 sends no data bits but still performs the enable and end-of-frame handshake.
- R10: If irq_i or timeout_i is high while busy, then in the next cycle tx_en_o and tx_data_o are 0, done_o is 1 and aborted_o is 1. The end-of-frame handshake is skipped.
- R11: aborted_o holds its value until the next accepted start, which clears it. A frame that completes normally leaves it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8 times the bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| byte_cnt_i | input | CNT_W | Number of byte words in the frame |
| parity_en_i | input | 1 | 1: 9 bits per word, 0: 8 bits per word |
| rd_addr_o | output | CNT_W | Word store read address |
| rd_data_i | input | WORD_W | Word store read data, one-cycle latency |
| bclk_i | input | 1 | Bit clock from the encoder, asynchronous |
| irq_i | input | 1 | Interrupt from the encoder, aborts the frame |
| timeout_i | input | 1 | Timeout flag, aborts the frame |
| tx_en_o | output | 1 | Transmit enable to the encoder |
| tx_data_o | output | 1 | Transmit data bit to the encoder |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at the end of a frame |
| aborted_o | output | 1 | Sticky: last frame ended by interrupt or timeout |

## Verification
The hardest situations to reach are those that depend on where an event falls relative to the bit clock. One is an abort in the middle of a frame. Another is a stray start pulse while a frame is running. A third is the trailing handshake, where the enable must survive exactly one extra clock edge. The bench models the encoder itself. It produces the bit clock only while the engine is busy, samples the data line just before each falling edge, and counts falling edges. This lets it inject an interrupt, a timeout or a second start after a chosen number of edges. At the done pulse it checks both the number of latched bits and the number of edges seen.

// File: rtl/btx_pkg.sv
package btx_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_REQ,
    ST_LOAD,
    ST_BIT_LO,
    ST_BIT_HI,
    ST_TAIL_LO,
    ST_TAIL_HI,
    ST_DROP_LO,
    ST_DROP_HI
  } btx_state_e;
endpackage

// File: rtl/btx_bclk_sync.sv
module btx_bclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b0;
    else         sync_q[0] <= bclk_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[s] <= 1'b0;
      else         sync_q[s] <= sync_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/btx_word_reg.sv
module btx_word_reg #(
  parameter int WORD_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [IDX_W-1:0]  sel_i,
  output logic              bit_o
);
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_q <= '0;
    else if (load_i) word_q <= word_i;
  end

  assign bit_o = word_q[sel_i];
endmodule

// File: rtl/bclk_tx_engine.sv
module bclk_tx_engine
  import btx_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int CNT_W       = 8,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  byte_cnt_i,
  input  logic              parity_en_i,
  output logic [CNT_W-1:0]  rd_addr_o,
  input  logic [WORD_W-1:0] rd_data_i,
  input  logic              bclk_i,
  input  logic              irq_i,
  input  logic              timeout_i,
  output logic              tx_en_o,
  output logic              tx_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              aborted_o
);
  localparam int IDX_W = $clog2(WORD_W);
  localparam logic [IDX_W-1:0] LAST_PLAIN = IDX_W'(DATA_BITS - 1);
  localparam logic [IDX_W-1:0] LAST_PAR   = IDX_W'(DATA_BITS);

  btx_state_e       state_q;
  logic [CNT_W-1:0] byte_idx_q, cnt_q;
  logic [IDX_W-1:0] bit_idx_q;
  logic             par_q;
  logic             bclk_level, bclk_rise;
  logic             cur_bit, last_bit, last_byte, abort;

  btx_bclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bclk_i  (bclk_i),
    .level_o (bclk_level),
    .rise_o  (bclk_rise)
  );

  btx_word_reg #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_word (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (state_q == ST_LOAD),
    .word_i (rd_data_i),
    .sel_i  (bit_idx_q),
    .bit_o  (cur_bit)
  );

  assign last_bit  = bit_idx_q == (par_q ? LAST_PAR : LAST_PLAIN);
  assign last_byte = byte_idx_q == (cnt_q - 1'b1);
  assign abort     = irq_i | timeout_i;
  assign rd_addr_o = byte_idx_q;
  assign busy_o    = state_q != ST_IDLE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      byte_idx_q <= '0;
      cnt_q      <= '0;
      bit_idx_q  <= '0;
      par_q      <= 1'b0;
      tx_en_o    <= 1'b0;
      tx_data_o  <= 1'b0;
      done_o     <= 1'b0;
      aborted_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (state_q != ST_IDLE && abort) begin
        // abort from any busy state, handshake skipped
        tx_en_o   <= 1'b0;
        tx_data_o <= 1'b0;
        done_o    <= 1'b1;
        aborted_o <= 1'b1;
        state_q   <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_IDLE: if (start_i) begin
            aborted_o  <= 1'b0;
            tx_data_o  <= 1'b0;
            cnt_q      <= byte_cnt_i;
            par_q      <= parity_en_i;
            byte_idx_q <= '0;
            bit_idx_q  <= '0;
            if (byte_cnt_i == '0) begin
              tx_en_o <= 1'b1;
              state_q <= ST_TAIL_LO;
            end else begin
              state_q <= ST_REQ;
            end
          end
          ST_REQ:  state_q <= ST_LOAD;
          ST_LOAD: begin
            tx_en_o <= 1'b1;
            state_q <= ST_BIT_LO;
          end
          ST_BIT_LO: if (!bclk_level) state_q <= ST_BIT_HI;
          ST_BIT_HI: if (bclk_rise) begin
            tx_data_o <= cur_bit;
            if (last_bit) begin
              bit_idx_q <= '0;
              if (last_byte) begin
                state_q <= ST_TAIL_LO;
              end else begin
                byte_idx_q <= byte_idx_q + 1'b1;
                state_q    <= ST_REQ;
              end
            end else begin
              bit_idx_q <= bit_idx_q + 1'b1;
              state_q   <= ST_BIT_LO;
            end
          end
          ST_TAIL_LO: if (!bclk_level) state_q <= ST_TAIL_HI;
          ST_TAIL_HI: if (bclk_rise) begin
            tx_en_o   <= 1'b0;
            tx_data_o <= 1'b0;
            state_q   <= ST_DROP_LO;
          end
          ST_DROP_LO: if (!bclk_level) state_q <= ST_DROP_HI;
          ST_DROP_HI: if (bclk_rise) begin
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/btx_checker.sv
module btx_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic irq_i,
  input logic timeout_i,
  input logic tx_en_o,
  input logic tx_data_o,
  input logic busy_o,
  input logic done_o,
  input logic aborted_o,
  input logic bclk_rise
);
  // R3
  data_low_at_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_en_o) |-> !tx_data_o);

  // R5
  data_moves_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_o && $past(tx_en_o) && (tx_data_o != $past(tx_data_o))) |-> $past(bclk_rise));

  // R10
  abort_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (irq_i || timeout_i)) |=> (!tx_en_o && !tx_data_o && done_o && aborted_o));

  // R8
  done_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  done_when_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !tx_en_o));

  // R11
  aborted_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aborted_o && !start_i) |=> aborted_o);

  // R2
  start_from_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && !aborted_o));
endmodule

bind bclk_tx_engine btx_checker u_btx_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .irq_i     (irq_i),
  .timeout_i (timeout_i),
  .tx_en_o   (tx_en_o),
  .tx_data_o (tx_data_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .aborted_o (aborted_o),
  .bclk_rise (bclk_rise)
);

// File: tb/sim_bclk_tx_engine.sv
module sim_bclk_tx_engine;
  localparam int CNT_W  = 8;
  localparam int WORD_W = 16;
  localparam int HALF   = 8;
  localparam int NVEC   = 6;
  // {count[3:0], parity, seed[15:0]}
  localparam logic [20:0] VECS [NVEC] = '{
    {4'd3, 1'b0, 16'hA5C3},
    {4'd2, 1'b1, 16'hFE01},
    {4'd5, 1'b0, 16'h1234},
    {4'd4, 1'b1, 16'h8F70},
    {4'd1, 1'b0, 16'h00FF},
    {4'd7, 1'b1, 16'hFFFF}
  };

  logic clk = 1'b0, rst_ni = 1'b0, start = 1'b0, parity = 1'b0;
  logic bclk = 1'b0, irq = 1'b0, tmo = 1'b0;
  logic [CNT_W-1:0]  byte_cnt = '0;
  logic [CNT_W-1:0]  rd_addr;
  logic [WORD_W-1:0] rd_data;
  logic [WORD_W-1:0] mem [256];
  logic tx_en, tx_data, busy, done, aborted;

  int checks = 0, errors = 0;
  int cap_n = 0, falls = 0;
  logic cap_bits [256];
  logic first_data = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) rd_data <= mem[rd_addr];

  bclk_tx_engine u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .byte_cnt_i(byte_cnt),
    .parity_en_i(parity), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .bclk_i(bclk), .irq_i(irq), .timeout_i(tmo), .tx_en_o(tx_en),
    .tx_data_o(tx_data), .busy_o(busy), .done_o(done), .aborted_o(aborted)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // encoder model: clocks while busy, latches data before each falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni && tx_en) begin
        cap_n = 0;
        falls = 0;
        first_data = tx_data;
        while (busy) begin
          bclk = 1'b1;
          repeat (HALF) @(negedge clk);
          if (tx_en) begin
            cap_bits[cap_n] = tx_data;
            cap_n++;
          end
          bclk = 1'b0;
          falls++;
          repeat (HALF) @(negedge clk);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic fill(input int cnt, input logic [15:0] seed);
    for (int i = 0; i < cnt; i++) mem[i] = seed + 16'(i * 16'h1357);
  endtask

  task automatic run_frame(input int cnt, input bit par, input int abort_at, input bit use_irq,
                           input bit extra_start, output int n_out, output int f_out,
                           output bit ab_out);
    bit got = 0, fired = 0, xs = 0;
    @(negedge clk);
    start = 1'b1; byte_cnt = CNT_W'(cnt); parity = par;
    @(negedge clk);
    start = 1'b0;
    while (!tx_en) @(negedge clk);
    @(negedge clk);
    while (!got) begin
      @(negedge clk);
      if (done) begin
        got = 1;
      end else if (abort_at >= 0 && !fired && falls >= abort_at) begin
        if (use_irq) irq = 1'b1; else tmo = 1'b1;
        fired = 1;
        @(negedge clk);
        // R10: enable and data low, done and aborted set the next cycle
        check(!tx_en && !tx_data && done && aborted, "R10 abort exit",
              {tx_en, tx_data, done, aborted}, 3);
        got = 1;
      end else if (extra_start && !xs && falls == 2) begin
        start = 1'b1; byte_cnt = 8'd1; xs = 1;
        @(negedge clk);
        start = 1'b0; byte_cnt = CNT_W'(cnt);
      end
    end
    n_out = cap_n;
    f_out = falls;
    ab_out = aborted;
    irq = 1'b0; tmo = 1'b0;
    repeat (3 * HALF) @(negedge clk);
  endtask

  task automatic check_frame(input int cnt, input bit par, input int n, input int f, input bit ab);
    int w = par ? 9 : 8;
    logic [15:0] got_w, exp_w;
    check(n == cnt * w, "R7 latched bit count", n, cnt * w);
    check(f == cnt * w + 1, "R8 falling edges before done", f, cnt * w + 1);
    check(ab == 1'b0, "R11 aborted after normal frame", ab, 0);
    check(first_data == 1'b0, "R3 data low at enable", first_data, 0);
    check(tx_data == 1'b0 && tx_en == 1'b0, "R3 lines idle after frame", {tx_en, tx_data}, 0);
    for (int i = 0; i < cnt; i++) begin
      got_w = '0;
      for (int b = 0; b < w; b++) got_w[b] = cap_bits[i * w + b];
      exp_w = mem[i] & (par ? 16'h01FF : 16'h00FF);
      check(got_w == exp_w, "R4 R5 R6 word bits", got_w, exp_w);
    end
  endtask

  initial begin
    int n, f;
    bit ab;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check({tx_en, tx_data, busy, done, aborted} == 5'b0, "R1 reset state",
          {tx_en, tx_data, busy, done, aborted}, 0);

    for (int v = 0; v < NVEC; v++) begin
      fill(int'(VECS[v][20:17]), VECS[v][15:0]);
      run_frame(int'(VECS[v][20:17]), VECS[v][16], -1, 0, 0, n, f, ab);
      check_frame(int'(VECS[v][20:17]), VECS[v][16], n, f, ab);
    end

    // R9: empty frame
    run_frame(0, 0, -1, 0, 0, n, f, ab);
    check(n == 0, "R9 no data bits", n, 0);
    check(f == 1, "R9 handshake edges", f, 1);
    check(ab == 0, "R9 not aborted", ab, 0);

    // R2: start during a frame is ignored
    fill(3, 16'h6B2D);
    run_frame(3, 1, -1, 0, 1, n, f, ab);
    check_frame(3, 1, n, f, ab);

    // R10: interrupt mid frame
    fill(5, 16'h3C3C);
    run_frame(5, 0, 10, 1, 0, n, f, ab);
    check(ab == 1, "R10 aborted on interrupt", ab, 1);
    check(n < 40, "R10 frame cut short", n, 40);
    repeat (30) @(negedge clk);
    check(aborted == 1'b1, "R11 aborted sticky", aborted, 1);

    // R11: next start clears it
    fill(1, 16'h0055);
    run_frame(1, 0, -1, 0, 0, n, f, ab);
    check_frame(1, 0, n, f, ab);

    // R10: timeout mid frame
    fill(4, 16'hC001);
    run_frame(4, 1, 5, 0, 0, n, f, ab);
    check(ab == 1, "R10 aborted on timeout", ab, 1);
    check(busy == 1'b0 && tx_en == 1'b0, "R10 idle after timeout", {busy, tx_en}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule